// File: doc/BRIEF.md
# Shared-Bus Master Interface Controller

This block holds the bus-facing control logic of one master on a multi-master system bus whose address, control, data and transfer-type lines are tristate and shared. It pairs two state machines that run on opposite clock edges. A grant tracker, updated on the rising edge, decides whether the arbiter's grant has actually taken effect. It does so by watching the grant line together with the wait response. A six-state transfer controller, updated on the falling edge, walks the master through idle, waiting for the bus, bus turnaround, active transfers and retracted transfers.

The master core raises a request and supplies the transfer type it wants. The block answers with the transfer type actually placed on the bus, a clock enable that stalls the core when it cannot proceed, and three tristate enables: one for address and control, one for data and one for the transfer-type driver. The wait, error and last responses from the slaves are captured on the rising edge. The falling-edge controller uses those captured copies when it leaves the active state. Both machines come out of reset in a state that the grant input picks, so that exactly one master in the system can start as the default owner of the bus.

Top module: `busMasterCtl`

## Requirements
- R1: The grant tracker updates on the rising clock edge. While `waitRsp` is high it keeps its value. While `waitRsp` is low it takes the value of `grantIn`. It becomes granted only when `grantIn` is high and `waitRsp` is low at that edge.
- R2: While `rstN` is low, both machines are held asynchronously in a state picked by `grantIn`. With `grantIn` high the tracker is granted and the controller is in BUSIDLE. With `grantIn` low the tracker is not granted and the controller is in IDLE.
- R3: Outside ACTIVE and RETRACT, the controller moves on each falling edge using only granted (G) and `reqIn` (R). IDLE goes to HANDOVER on G&R, to BUSIDLE on G&!R, to HOLD on !G&R, and otherwise stays. BUSIDLE goes to ACTIVE on G&R, stays on G&!R, goes to HOLD on !G&R, and goes to IDLE on !G&!R. HOLD stays while !G and goes to HANDOVER on G. HANDOVER goes to ACTIVE on G and back to HOLD on !G.
- R4: In ACTIVE, the captured response decides the next state. A wait keeps the controller in ACTIVE. A retract goes to RETRACT. Done, last and error all leave in the same way: to ACTIVE on G&R, BUSIDLE on G&!R, HOLD on !G&R and IDLE on !G&!R.
- R5: RETRACT goes to HANDOVER when granted and to HOLD when not granted.
- R6: `transOut` is 2'b00 (address-only) in IDLE, HOLD and RETRACT, and 2'b11 (sequential) in HANDOVER. In BUSIDLE and ACTIVE it equals `coreTrans`.
- R7: `coreClkEn` is 1 in IDLE and BUSIDLE, and 0 in HOLD, HANDOVER and RETRACT. In ACTIVE it is the inverse of the captured wait.
- R8: `addrDrvEn` equals the tracker's granted value in BUSIDLE, HANDOVER, ACTIVE and RETRACT, and is 0 in IDLE and HOLD.
- R9: `dataDrvEn` is 1 only in ACTIVE or RETRACT while `isWrite` is high.
- R10: `transDrvEn` is 1 exactly when `grantIn` and `clk` are both high.
- R11: The captured response is decoded with wait taking precedence over everything else. With wait low: error and last together mean retract, error alone means error, last alone means last, and neither means done.
- R12: The controller enters ACTIVE only on a falling edge at which the tracker reports granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the tracker uses the rising edge, the controller the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| grantIn | input | 1 | Grant from the arbiter |
| waitRsp | input | 1 | Wait response from the addressed slave |
| errRsp | input | 1 | Error response |
| lastRsp | input | 1 | Last response |
| reqIn | input | 1 | Transfer request from the master core |
| coreTrans | input | 2 | Transfer type the core wants |
| isWrite | input | 1 | Current transfer is a write |
| transOut | output | 2 | Transfer type driven toward the bus |
| coreClkEn | output | 1 | Clock enable for the master core |
| addrDrvEn | output | 1 | Tristate enable for address and control lines |
| dataDrvEn | output | 1 | Tristate enable for the data lines |
| transDrvEn | output | 1 | Tristate enable for the transfer-type driver |

## Verification
The clash that matters is a grant withdrawal on the same rising edge that brings in a completing response. The tracker drops granted half a cycle before the falling edge at which the controller leaves ACTIVE, so the exit must see the new value and land in HOLD or IDLE, not stay in ACTIVE or go to BUSIDLE. The vector table drives this case with error, with done and with a retract. It also covers the opposite case, where the grant falls while wait is high: there the tracker must keep the bus and the controller must stall the core in ACTIVE. Each case is judged by the state-dependent outputs sampled just after the falling edge.

// File: rtl/busMasterPkg.sv
package busMasterPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSIDLE,
    ST_HOLD,
    ST_HANDOVER,
    ST_ACTIVE,
    ST_RETRACT
  } xferState_t;

  typedef enum logic [2:0] {
    RSP_WAIT,
    RSP_DONE,
    RSP_LAST,
    RSP_ERROR,
    RSP_RETRACT
  } rspKind_t;

  // strobes from the controller to the drive logic
  typedef struct packed {
    logic forceAddrOnly;
    logic forceSeq;
    logic ceOn;
    logic addrFollowGrant;
    logic dataOnWrite;
  } ctlStrobe_t;

endpackage

// File: rtl/grantTracker.sv
module grantTracker (
  input  logic clk,
  input  logic rstN,
  input  logic grantIn,
  input  logic waitRsp,
  output logic granted
);

  logic grantedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantedQ <= grantIn;
    end else if (!waitRsp) begin
      grantedQ <= grantIn;
    end
  end

  assign granted = grantedQ;

  // R1: a wait response freezes the tracker
  assert_wait_freeze_R1: assert property (@(posedge clk) disable iff (!rstN)
    waitRsp |=> $stable(granted));

  // R1: with wait low the tracker follows the grant line
  assert_follow_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    !waitRsp |=> (granted == $past(grantIn)));

endmodule

// File: rtl/xferCtrl.sv
module xferCtrl
  import busMasterPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       grantIn,
  input  logic       waitRsp,
  input  logic       errRsp,
  input  logic       lastRsp,
  input  logic       reqIn,
  input  logic       granted,
  output ctlStrobe_t strobes
);

  xferState_t state;
  xferState_t stateNext;
  logic       latWait;
  logic       latErr;
  logic       latLast;
  rspKind_t   rspKind;

  // responses are captured on the rising edge for the falling-edge machine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latWait <= 1'b0;
      latErr  <= 1'b0;
      latLast <= 1'b0;
    end else begin
      latWait <= waitRsp;
      latErr  <= errRsp;
      latLast <= lastRsp;
    end
  end

  function automatic rspKind_t decodeRsp(input logic w, input logic e, input logic l);
    if (w)           return RSP_WAIT;
    else if (e && l) return RSP_RETRACT;
    else if (e)      return RSP_ERROR;
    else if (l)      return RSP_LAST;
    else             return RSP_DONE;
  endfunction

  function automatic xferState_t settleState(input logic g, input logic r);
    case ({g, r})
      2'b11:   return ST_ACTIVE;
      2'b10:   return ST_BUSIDLE;
      2'b01:   return ST_HOLD;
      default: return ST_IDLE;
    endcase
  endfunction

  assign rspKind = decodeRsp(latWait, latErr, latLast);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        case ({granted, reqIn})
          2'b11:   stateNext = ST_HANDOVER;
          2'b10:   stateNext = ST_BUSIDLE;
          2'b01:   stateNext = ST_HOLD;
          default: stateNext = ST_IDLE;
        endcase
      end
      ST_BUSIDLE:  stateNext = settleState(granted, reqIn);
      ST_HOLD:     stateNext = granted ? ST_HANDOVER : ST_HOLD;
      ST_HANDOVER: stateNext = granted ? ST_ACTIVE : ST_HOLD;
      ST_ACTIVE: begin
        case (rspKind)
          RSP_WAIT:    stateNext = ST_ACTIVE;
          RSP_RETRACT: stateNext = ST_RETRACT;
          default:     stateNext = settleState(granted, reqIn);
        endcase
      end
      ST_RETRACT:  stateNext = granted ? ST_HANDOVER : ST_HOLD;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= grantIn ? ST_BUSIDLE : ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: begin
        strobes.forceAddrOnly = 1'b1;
        strobes.ceOn          = 1'b1;
      end
      ST_BUSIDLE: begin
        strobes.ceOn            = 1'b1;
        strobes.addrFollowGrant = 1'b1;
      end
      ST_HOLD: begin
        strobes.forceAddrOnly = 1'b1;
      end
      ST_HANDOVER: begin
        strobes.forceSeq        = 1'b1;
        strobes.addrFollowGrant = 1'b1;
      end
      ST_ACTIVE: begin
        strobes.ceOn            = !latWait;
        strobes.addrFollowGrant = 1'b1;
        strobes.dataOnWrite     = 1'b1;
      end
      ST_RETRACT: begin
        strobes.forceAddrOnly   = 1'b1;
        strobes.addrFollowGrant = 1'b1;
        strobes.dataOnWrite     = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  // R12: the entry into ACTIVE happens only while the tracker reports granted
  assert_active_entry_granted_R12: assert property (@(negedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |-> $past(granted));

  // R4: a captured wait keeps the controller in ACTIVE
  assert_wait_stays_R4: assert property (@(negedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && latWait) |=> (state == ST_ACTIVE));

  // R4 and R11: error with last (and wait low) retracts the transfer
  assert_retract_path_R4: assert property (@(negedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !latWait && latErr && latLast) |=> (state == ST_RETRACT));

  // R3: HOLD is kept until the grant takes effect
  assert_hold_waits_R3: assert property (@(negedge clk) disable iff (!rstN)
    (state == ST_HOLD && !granted) |=> (state == ST_HOLD));

endmodule

// File: rtl/xferDrive.sv
module xferDrive
  import busMasterPkg::*;
#(
  parameter int TRANS_W = 2,
  parameter logic [TRANS_W-1:0] ADDR_ONLY_CODE = '0,
  parameter logic [TRANS_W-1:0] SEQ_CODE       = '1
) (
  input  logic               clk,
  input  logic               grantIn,
  input  logic               granted,
  input  logic               isWrite,
  input  logic [TRANS_W-1:0] coreTrans,
  input  ctlStrobe_t         strobes,
  output logic [TRANS_W-1:0] transOut,
  output logic               coreClkEn,
  output logic               addrDrvEn,
  output logic               dataDrvEn,
  output logic               transDrvEn
);

  always_comb begin
    if (strobes.forceAddrOnly)  transOut = ADDR_ONLY_CODE;
    else if (strobes.forceSeq)  transOut = SEQ_CODE;
    else                        transOut = coreTrans;
  end

  assign coreClkEn  = strobes.ceOn;
  assign addrDrvEn  = strobes.addrFollowGrant & granted;
  assign dataDrvEn  = strobes.dataOnWrite & isWrite;
  assign transDrvEn = grantIn & clk;

endmodule

// File: rtl/busMasterCtl.sv
module busMasterCtl
  import busMasterPkg::*;
#(
  parameter int TRANS_W = 2,
  parameter logic [TRANS_W-1:0] ADDR_ONLY_CODE = 2'b00,
  parameter logic [TRANS_W-1:0] SEQ_CODE       = 2'b11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               grantIn,
  input  logic               waitRsp,
  input  logic               errRsp,
  input  logic               lastRsp,
  input  logic               reqIn,
  input  logic [TRANS_W-1:0] coreTrans,
  input  logic               isWrite,
  output logic [TRANS_W-1:0] transOut,
  output logic               coreClkEn,
  output logic               addrDrvEn,
  output logic               dataDrvEn,
  output logic               transDrvEn
);

  logic       granted;
  ctlStrobe_t strobes;

  grantTracker i_grantTracker (
    .clk     (clk),
    .rstN    (rstN),
    .grantIn (grantIn),
    .waitRsp (waitRsp),
    .granted (granted)
  );

  xferCtrl i_xferCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .grantIn (grantIn),
    .waitRsp (waitRsp),
    .errRsp  (errRsp),
    .lastRsp (lastRsp),
    .reqIn   (reqIn),
    .granted (granted),
    .strobes (strobes)
  );

  xferDrive #(
    .TRANS_W        (TRANS_W),
    .ADDR_ONLY_CODE (ADDR_ONLY_CODE),
    .SEQ_CODE       (SEQ_CODE)
  ) i_xferDrive (
    .clk        (clk),
    .grantIn    (grantIn),
    .granted    (granted),
    .isWrite    (isWrite),
    .coreTrans  (coreTrans),
    .strobes    (strobes),
    .transOut   (transOut),
    .coreClkEn  (coreClkEn),
    .addrDrvEn  (addrDrvEn),
    .dataDrvEn  (dataDrvEn),
    .transDrvEn (transDrvEn)
  );

endmodule

// File: tb/test_busMasterCtl.sv
module test_busMasterCtl;

  logic       clk = 1'b0;
  logic       rstN;
  logic       grantIn, waitRsp, errRsp, lastRsp, reqIn, isWrite;
  logic [1:0] coreTrans;
  logic [1:0] transOut;
  logic       coreClkEn, addrDrvEn, dataDrvEn, transDrvEn;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  busMasterCtl i_busMasterCtl (
    .clk        (clk),
    .rstN       (rstN),
    .grantIn    (grantIn),
    .waitRsp    (waitRsp),
    .errRsp     (errRsp),
    .lastRsp    (lastRsp),
    .reqIn      (reqIn),
    .coreTrans  (coreTrans),
    .isWrite    (isWrite),
    .transOut   (transOut),
    .coreClkEn  (coreClkEn),
    .addrDrvEn  (addrDrvEn),
    .dataDrvEn  (dataDrvEn),
    .transDrvEn (transDrvEn)
  );

  // fields: grant wait err last req coreTrans[1:0] write | expTrans[1:0] expCe expAddr expData
  localparam int NVEC = 34;
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_0_0_0_0_10_0_00_1_0_0, // 0  IDLE stays (R3)
    13'b0_0_0_0_1_10_0_00_0_0_0, // 1  IDLE->HOLD (R3)
    13'b1_1_0_0_1_10_0_00_0_0_0, // 2  wait blocks grant, HOLD kept (R1)
    13'b1_0_0_0_1_10_0_11_0_1_0, // 3  HOLD->HANDOVER (R1, R3)
    13'b1_0_0_0_1_10_1_10_1_1_1, // 4  HANDOVER->ACTIVE write (R12)
    13'b1_1_0_0_1_11_1_11_0_1_1, // 5  wait keeps ACTIVE (R4, R11)
    13'b1_0_0_0_1_11_0_11_1_1_0, // 6  done G&R stays ACTIVE (R4)
    13'b1_0_1_1_1_10_1_00_0_1_1, // 7  retract (R4, R11)
    13'b1_0_0_0_1_10_1_11_0_1_0, // 8  RETRACT->HANDOVER (R5)
    13'b1_0_0_0_1_10_0_10_1_1_0, // 9  ACTIVE
    13'b1_0_0_1_0_01_0_01_1_1_0, // 10 last G&!R -> BUSIDLE (R4, R11)
    13'b1_0_0_0_0_00_0_00_1_1_0, // 11 BUSIDLE stays (R3)
    13'b1_0_0_0_1_10_0_10_1_1_0, // 12 BUSIDLE->ACTIVE (R3)
    13'b0_0_1_0_1_10_0_00_0_0_0, // 13 error with grant lost -> HOLD (R4, R11)
    13'b0_0_0_0_1_10_0_00_0_0_0, // 14 HOLD
    13'b1_0_0_0_1_10_0_11_0_1_0, // 15 HANDOVER
    13'b0_0_0_0_1_10_0_00_0_0_0, // 16 HANDOVER->HOLD (R3)
    13'b1_0_0_0_1_10_0_11_0_1_0, // 17 HANDOVER
    13'b1_0_0_0_1_10_0_10_1_1_0, // 18 ACTIVE
    13'b0_0_0_0_0_10_0_00_1_0_0, // 19 done !G&!R -> IDLE (R4)
    13'b1_0_0_0_0_01_0_01_1_1_0, // 20 IDLE->BUSIDLE (R3)
    13'b0_0_0_0_0_01_0_00_1_0_0, // 21 BUSIDLE->IDLE (R3)
    13'b1_0_0_0_1_10_0_11_0_1_0, // 22 IDLE->HANDOVER (R3)
    13'b1_0_0_0_1_10_1_10_1_1_1, // 23 ACTIVE write (R9)
    13'b0_1_0_0_1_10_1_10_0_1_1, // 24 grant drops under wait (R1, R7)
    13'b0_0_0_0_1_10_0_00_0_0_0, // 25 done !G&R -> HOLD (R4)
    13'b1_0_0_0_1_10_0_11_0_1_0, // 26 HANDOVER
    13'b1_0_0_0_0_00_0_00_1_1_0, // 27 ACTIVE (R6)
    13'b1_0_0_0_0_10_0_10_1_1_0, // 28 done G&!R -> BUSIDLE (R4)
    13'b0_0_0_0_1_10_0_00_0_0_0, // 29 BUSIDLE->HOLD (R3)
    13'b1_0_0_0_1_00_0_11_0_1_0, // 30 HANDOVER
    13'b1_0_0_0_1_10_0_10_1_1_0, // 31 ACTIVE
    13'b1_0_1_1_1_10_0_00_0_1_0, // 32 retract, read (R9)
    13'b0_0_0_0_1_10_0_00_0_0_0  // 33 RETRACT->HOLD (R5)
  };

  task automatic chk1(input string tag, input int idx, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s step %0d: actual %b expected %b", tag, idx, act, exp);
    end
  endtask

  task automatic chkOuts(input int idx, input logic [1:0] eT, input logic eC,
                         input logic eA, input logic eD);
    nChecks++;
    if (transOut !== eT) begin
      nFails++;
      $display("FAIL R6 step %0d: transOut actual %b expected %b", idx, transOut, eT);
    end
    chk1("R7 coreClkEn", idx, coreClkEn, eC);
    chk1("R8 addrDrvEn", idx, addrDrvEn, eA);
    chk1("R9 dataDrvEn", idx, dataDrvEn, eD);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog expired, run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; grantIn = 1'b0; waitRsp = 1'b0; errRsp = 1'b0; lastRsp = 1'b0;
    reqIn = 1'b0; coreTrans = 2'b10; isWrite = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R2: non-default master resets to IDLE outputs
    chkOuts(-1, 2'b00, 1'b1, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      {grantIn, waitRsp, errRsp, lastRsp, reqIn, coreTrans, isWrite} = VEC[k][12:5];
      @(negedge clk);
      #1;
      chkOuts(k, VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R2: default master (grant high during reset) starts in BUSIDLE, granted
    grantIn = 1'b1; waitRsp = 1'b0; errRsp = 1'b0; lastRsp = 1'b0;
    reqIn = 1'b0; coreTrans = 2'b01; isWrite = 1'b1;
    rstN = 1'b0;
    #1;
    chkOuts(100, 2'b01, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // BUSIDLE kept after release (R3)
    chkOuts(101, 2'b01, 1'b1, 1'b1, 1'b0);

    // R2: reset asserted mid-run with grant low forces IDLE at once
    grantIn = 1'b0;
    rstN = 1'b0;
    #1;
    chkOuts(102, 2'b00, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    rstN = 1'b1;

    // R10: transfer-type driver follows grant AND clock
    grantIn = 1'b1;
    @(posedge clk);
    #1;
    chk1("R10 transDrvEn clk high grant high", 103, transDrvEn, 1'b1);
    @(negedge clk);
    #1;
    chk1("R10 transDrvEn clk low grant high", 104, transDrvEn, 1'b0);
    grantIn = 1'b0;
    @(posedge clk);
    #1;
    chk1("R10 transDrvEn clk high grant low", 105, transDrvEn, 1'b0);
    @(negedge clk);
    #1;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule